// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the general-purpose registers of a 32-bit processor core that runs in one of seven operating modes. Software always sees sixteen register names, 0 to 15, but the physical storage behind some of those names changes with the current mode. The low eight names always reach one shared copy. Names 8 to 12 have a private copy for the fast-interrupt mode. Names 13 and 14 have one copy for each exception mode, plus a copy that user and system modes share. In total there are 31 physical 32-bit registers, including the program counter.

The core reads two operands per cycle through combinational read ports and retires one result per cycle through a synchronous write port. Every access is steered by the 5-bit mode input. Name 15 is the program counter. An operand read of it returns the stored address plus 8, so that it looks ahead of the fetch. A write to it is a branch: the two low bits are dropped, and a one-cycle pulse is raised. An unrecognised mode code is flagged, and the accesses made under it use the user copies.

The ports are plain register-file ports driven every cycle. There is no valid/ready handshake and no back-pressure: a read is answered in the same cycle, and a write is always accepted at the next rising edge.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-high reset clears all 31 physical registers and `branch_taken`. After reset every name from 0 to 14 reads zero in every mode, `pc_out` is zero, and name 15 reads 8.
- R2: Names 0 to 7 map to one physical copy that all modes share. A value written in one mode reads back unchanged in any other mode.
- R3: Names 8 to 12 have two copies each. Mode 5'b10001 (fast interrupt) uses its own copy. All other modes, and invalid modes, share the other copy.
- R4: Names 13 and 14 have six copies each. User (5'b10000) and system (5'b11111) share one copy. Fast interrupt (5'b10001), IRQ (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) each have a private copy.
- R5: `invalid_mode` is 1 exactly when `mode` is none of the seven codes listed in R3 and R4.
- R6: While `invalid_mode` is 1, reads and writes use the user-mode copies.
- R7: A read of name 15 on either read port returns `pc_out + 8`.
- R8: A write to name 15 loads the program counter with `wr_data` with bits [1:0] forced to 0. The new value is visible on `pc_out` in the cycle after the write edge. The program counter changes only through such a write.
- R9: `branch_taken` is 1 for exactly the one cycle that follows a clock edge at which a write to name 15 occurred, and is 0 otherwise.
- R10: A read of the register that is being written in the same cycle returns the old value. The new value is returned from the next cycle on.
- R11: The two read ports are independent: each returns its own addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 5 | Current operating mode code |
| rd_a_addr | input | 4 | Register name read on port A |
| rd_a_data | output | 32 | Port A read data (combinational) |
| rd_b_addr | input | 4 | Register name read on port B |
| rd_b_data | output | 32 | Port B read data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 4 | Register name to write |
| wr_data | input | 32 | Write data |
| pc_out | output | 32 | Stored program counter |
| branch_taken | output | 1 | One-cycle pulse after a write to name 15 |
| invalid_mode | output | 1 | Mode code is not a defined mode |

## Verification
The bench writes a different value into name 13 in every mode and reads each one back. A design that split user from system, or that merged two exception copies, returns the wrong value for at least one mode. It then checks that a fast-interrupt write to name 8 leaves the shared copy untouched, which catches a mapping that banks the wrong range. For name 15 it writes an unaligned address and expects `pc_out` to be aligned, operand reads to return that address plus 8, and `branch_taken` to be high for one cycle only. An off-by-eight read, a missing mask or a stuck pulse all produce a mismatch. An invalid mode code must raise the flag and reach the user/system copy, and a read of the register being written in the same cycle must return the old data, which exposes any accidental bypass.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;
  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  localparam int NUM_BANKS   = 6;
  localparam int NUM_SHARED  = 8;   // names 0..7
  localparam int NUM_FIQBANK = 5;   // names 8..12
  localparam int SP_NAME     = 13;
  localparam int LR_NAME     = 14;
  localparam int PC_NAME     = 15;

  localparam int FIQ_BASE = NUM_SHARED + NUM_FIQBANK;      // 13
  localparam int SP_BASE  = FIQ_BASE + NUM_FIQBANK;        // 18
  localparam int LR_BASE  = SP_BASE + NUM_BANKS;           // 24
  localparam int PC_IDX   = LR_BASE + NUM_BANKS;           // 30
  localparam int NUM_PHYS = PC_IDX + 1;                    // 31
  localparam int PHYS_W   = $clog2(NUM_PHYS);

  localparam logic [4:0] MD_USR = 5'b10000;
  localparam logic [4:0] MD_FIQ = 5'b10001;
  localparam logic [4:0] MD_IRQ = 5'b10010;
  localparam logic [4:0] MD_SVC = 5'b10011;
  localparam logic [4:0] MD_ABT = 5'b10111;
  localparam logic [4:0] MD_UND = 5'b11011;
  localparam logic [4:0] MD_SYS = 5'b11111;
endpackage

// File: rtl/mode_decode.sv
module mode_decode
  import bankreg_pkg::*;
(
  input  logic [4:0] mode,
  output bank_e      bank,
  output logic       bad
);
  always_comb begin
    bad  = 1'b0;
    bank = BK_USR;
    case (mode)
      MD_USR, MD_SYS: bank = BK_USR;
      MD_FIQ:         bank = BK_FIQ;
      MD_IRQ:         bank = BK_IRQ;
      MD_SVC:         bank = BK_SVC;
      MD_ABT:         bank = BK_ABT;
      MD_UND:         bank = BK_UND;
      default: begin
        bank = BK_USR;
        bad  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/phys_map.sv
module phys_map
  import bankreg_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic [AW-1:0]     name,
  input  bank_e             bank,
  output logic [PHYS_W-1:0] phys,
  output logic              is_pc
);
  localparam int FIQ_END = NUM_SHARED + NUM_FIQBANK;

  logic [PHYS_W-1:0] name_w;
  logic [PHYS_W-1:0] bank_w;

  assign name_w = PHYS_W'(name);
  assign bank_w = PHYS_W'(bank);

  always_comb begin
    is_pc = 1'b0;
    phys  = name_w;
    if (32'(name) < NUM_SHARED) begin
      phys = name_w;
    end else if (32'(name) < FIQ_END) begin
      if (bank == BK_FIQ)
        phys = name_w - PHYS_W'(NUM_SHARED) + PHYS_W'(FIQ_BASE);
      else
        phys = name_w;
    end else if (32'(name) == SP_NAME) begin
      phys = PHYS_W'(SP_BASE) + bank_w;
    end else if (32'(name) == LR_NAME) begin
      phys = PHYS_W'(LR_BASE) + bank_w;
    end else begin
      phys  = PHYS_W'(PC_IDX);
      is_pc = 1'b1;
    end
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankreg_pkg::*;
#(
  parameter int DW        = 32,
  parameter int AW        = 4,
  parameter int PC_AHEAD  = 8,
  parameter int ALIGN_LSB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [4:0]    mode,
  input  logic [AW-1:0] rd_a_addr,
  output logic [DW-1:0] rd_a_data,
  input  logic [AW-1:0] rd_b_addr,
  output logic [DW-1:0] rd_b_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] pc_out,
  output logic          branch_taken,
  output logic          invalid_mode
);
  localparam int NRD = 2;

  logic [DW-1:0] regs [NUM_PHYS];
  bank_e         cur_bank;

  mode_decode u_mdec (
    .mode (mode),
    .bank (cur_bank),
    .bad  (invalid_mode)
  );

  logic [AW-1:0]     rd_name [NRD];
  logic [DW-1:0]     rd_val  [NRD];
  logic [PHYS_W-1:0] rd_phys [NRD];
  logic              rd_pc   [NRD];

  assign rd_name[0] = rd_a_addr;
  assign rd_name[1] = rd_b_addr;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    phys_map #(.AW(AW)) u_map (
      .name  (rd_name[p]),
      .bank  (cur_bank),
      .phys  (rd_phys[p]),
      .is_pc (rd_pc[p])
    );
    assign rd_val[p] = rd_pc[p] ? (regs[PC_IDX] + DW'(PC_AHEAD))
                                : regs[rd_phys[p]];
  end

  assign rd_a_data = rd_val[0];
  assign rd_b_data = rd_val[1];

  logic [PHYS_W-1:0] wr_phys;
  logic              wr_pc;

  phys_map #(.AW(AW)) u_wmap (
    .name  (wr_addr),
    .bank  (cur_bank),
    .phys  (wr_phys),
    .is_pc (wr_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PHYS; i++) regs[i] <= '0;
      branch_taken <= 1'b0;
    end else begin
      branch_taken <= 1'b0;
      if (wr_en) begin
        if (wr_pc) begin
          regs[PC_IDX] <= {wr_data[DW-1:ALIGN_LSB], {ALIGN_LSB{1'b0}}};
          branch_taken <= 1'b1;
        end else begin
          regs[wr_phys] <= wr_data;
        end
      end
    end
  end

  assign pc_out = regs[PC_IDX];
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] rd_a_addr,
  input logic [DW-1:0] rd_a_data,
  input logic [AW-1:0] rd_b_addr,
  input logic [DW-1:0] rd_b_data,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] pc_out,
  input logic          branch_taken
);
  logic pc_wr;
  assign pc_wr = wr_en && (wr_addr == AW'(15));

  // R8
  pc_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    pc_out[1:0] == 2'b00);

  // R8
  pc_load_chk: assert property (@(posedge clk) disable iff (rst)
    pc_wr |=> pc_out == {$past(wr_data[DW-1:2]), 2'b00});

  // R8
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pc_wr |=> $stable(pc_out));

  // R9
  branch_follows_chk: assert property (@(posedge clk) disable iff (rst)
    pc_wr |=> branch_taken);

  // R9
  branch_source_chk: assert property (@(posedge clk) disable iff (rst)
    !pc_wr |=> !branch_taken);

  // R7
  pc_ahead_a_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_a_addr == AW'(15)) |-> rd_a_data == pc_out + DW'(8));

  // R7
  pc_ahead_b_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_b_addr == AW'(15)) |-> rd_b_data == pc_out + DW'(8));
endmodule

bind banked_regfile banked_regfile_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rd_a_addr    (rd_a_addr),
  .rd_a_data    (rd_a_data),
  .rd_b_addr    (rd_b_addr),
  .rd_b_data    (rd_b_data),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .pc_out       (pc_out),
  .branch_taken (branch_taken)
);

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
  localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                         M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                         M_SYS = 5'b11111;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  mode = M_USR;
  logic [3:0]  rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, pc_out;
  logic        wr_en = 1'b0, branch_taken, invalid_mode;

  banked_regfile u_dut (
    .clk(clk), .rst(rst), .mode(mode),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pc_out(pc_out), .branch_taken(branch_taken), .invalid_mode(invalid_mode)
  );

  always #5 clk = ~clk;

  // Scoreboard item: which output (0 port A, 1 port B, 2 pc_out, 3 branch, 4 invalid)
  typedef struct {
    int          sel;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 1'b0;

  function automatic logic [31:0] observe(int sel);
    case (sel)
      0: return rd_a_data;
      1: return rd_b_data;
      2: return pc_out;
      3: return {31'd0, branch_taken};
      default: return {31'd0, invalid_mode};
    endcase
  endfunction

  // Monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (sbq.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sbq.pop_front();
        act = observe(it.sel);
        n_checks++;
        if (act !== it.exp) begin
          n_errors++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(int sel, logic [31:0] exp, string tag);
    item_t it;
    it.sel = sel; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic wr(logic [4:0] m, logic [3:0] a, logic [31:0] d);
    step();
    mode = m; wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] m, logic [3:0] a, logic [31:0] ea,
                    logic [3:0] b, logic [31:0] eb, string tag);
    step();
    mode = m; rd_a_addr = a; rd_b_addr = b;
    expect_out(0, ea, tag);
    expect_out(1, eb, tag);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    // R1 reset state
    rd(M_USR, 4'd0, 32'd0, 4'd13, 32'd0, "R1 reset regs");
    expect_out(2, 32'd0, "R1 reset pc_out");
    expect_out(3, 32'd0, "R1 reset branch");
    rd(M_FIQ, 4'd9, 32'd0, 4'd15, 32'd8, "R1 reset fiq/pc");

    // R2 shared low names
    for (int i = 0; i < 8; i++) wr(M_USR, 4'(i), 32'h1000_0000 + i);
    rd(M_FIQ, 4'd0, 32'h1000_0000, 4'd7, 32'h1000_0007, "R2 shared in fiq");
    rd(M_UND, 4'd3, 32'h1000_0003, 4'd5, 32'h1000_0005, "R2 shared in und R11");
    wr(M_IRQ, 4'd4, 32'hCAFE_0004);
    rd(M_SYS, 4'd4, 32'hCAFE_0004, 4'd6, 32'h1000_0006, "R2 write irq read sys");

    // R3 names 8..12
    wr(M_USR, 4'd8, 32'h0000_00A8);
    wr(M_FIQ, 4'd8, 32'h0000_00F8);
    wr(M_SVC, 4'd12, 32'h0000_00AC);
    rd(M_SVC, 4'd8, 32'h0000_00A8, 4'd12, 32'h0000_00AC, "R3 shared copy");
    rd(M_FIQ, 4'd8, 32'h0000_00F8, 4'd12, 32'h0000_0000, "R3 fiq copy");
    rd(M_SYS, 4'd8, 32'h0000_00A8, 4'd12, 32'h0000_00AC, "R3 sys sees shared");

    // R4 names 13/14
    wr(M_USR, 4'd13, 32'hD0); wr(M_FIQ, 4'd13, 32'hD1); wr(M_IRQ, 4'd13, 32'hD2);
    wr(M_SVC, 4'd13, 32'hD3); wr(M_ABT, 4'd13, 32'hD4); wr(M_UND, 4'd13, 32'hD5);
    wr(M_ABT, 4'd14, 32'hE4); wr(M_SYS, 4'd14, 32'hE0);
    rd(M_USR, 4'd13, 32'hD0, 4'd14, 32'hE0, "R4 user copy");
    rd(M_FIQ, 4'd13, 32'hD1, 4'd14, 32'h0,  "R4 fiq copy");
    rd(M_IRQ, 4'd13, 32'hD2, 4'd14, 32'h0,  "R4 irq copy");
    rd(M_SVC, 4'd13, 32'hD3, 4'd14, 32'h0,  "R4 svc copy");
    rd(M_ABT, 4'd13, 32'hD4, 4'd14, 32'hE4, "R4 abt copy");
    rd(M_UND, 4'd13, 32'hD5, 4'd14, 32'h0,  "R4 und copy");
    wr(M_SYS, 4'd13, 32'hDF);
    rd(M_USR, 4'd13, 32'hDF, 4'd14, 32'hE0, "R4 sys shares user");

    // R5 / R6 invalid modes
    rd(5'b00000, 4'd13, 32'hDF, 4'd8, 32'hA8, "R6 invalid uses user");
    expect_out(4, 32'd1, "R5 invalid 00000");
    rd(5'b10100, 4'd14, 32'hE0, 4'd2, 32'h1000_0002, "R6 invalid 10100");
    expect_out(4, 32'd1, "R5 invalid 10100");
    wr(5'b11000, 4'd14, 32'hEE);
    rd(M_USR, 4'd14, 32'hEE, 4'd13, 32'hDF, "R6 invalid write lands in user");
    expect_out(4, 32'd0, "R5 valid user");
    rd(M_UND, 4'd0, 32'h1000_0000, 4'd0, 32'h1000_0000, "R5 valid und");
    expect_out(4, 32'd0, "R5 valid und flag");

    // R7 R8 R9 program counter
    wr(M_SVC, 4'd15, 32'h0000_1003);
    expect_out(3, 32'd1, "R9 branch pulse");
    expect_out(2, 32'h0000_1000, "R8 pc aligned");
    rd(M_SVC, 4'd15, 32'h0000_1008, 4'd15, 32'h0000_1008, "R7 pc ahead");
    expect_out(3, 32'd0, "R9 pulse ends");
    wr(M_USR, 4'd1, 32'h55);
    expect_out(3, 32'd0, "R9 no pulse on other write");
    expect_out(2, 32'h0000_1000, "R8 pc unchanged");
    wr(M_FIQ, 4'd15, 32'hFFFF_FFFE);
    expect_out(2, 32'hFFFF_FFFC, "R8 pc mask high");
    rd(M_FIQ, 4'd15, 32'h0000_0004, 4'd1, 32'h55, "R7 pc wrap");

    // R10 read during write
    step();
    mode = M_USR; rd_a_addr = 4'd3; rd_b_addr = 4'd13;
    wr_en = 1'b1; wr_addr = 4'd3; wr_data = 32'h3333_3333;
    expect_out(0, 32'h1000_0003, "R10 old value");
    step();
    wr_en = 1'b0;
    expect_out(0, 32'h3333_3333, "R10 new value");
    expect_out(1, 32'hDF, "R11 other port");

    step(); step();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule